// File: doc/BRIEF.md
# Dual-Channel Digital Waveform Synthesizer

This block is a two-channel direct digital synthesis core. Each channel runs a phase accumulator that advances by its own tuning word on every sample clock. The top bits of the accumulator select a point in one of four shapes: sine, square, triangle or sawtooth. A per-channel gain scales the signed sample, which is then re-centred on the mid-code of a 10-bit unsigned DAC bus.

A host controller writes settings through a single-cycle register-write port. Every write lands in a pending copy. A channel copies its pending settings into use only when its accumulator wraps, so a waveform never changes shape, slope or level part-way through a period. In locked mode, channel B ignores its own accumulator and reads channel A's accumulator plus a programmable phase offset, so both outputs run at the same frequency with a fixed phase relation.

With a 50 MHz sample clock, a tuning word W gives W × 50e6 / 2^32 Hz. The step is about 0.012 Hz, well below 1 Hz across the 1–2 kHz band.

Top module: `dds_dual_gen`

## Requirements
- R1: While reset is low both outputs read 512. After reset each channel outputs a full-scale sine with tuning word 85899 (1 kHz at 50 MHz), gain 255, duty 50 and locked mode off.
- R2: Each accumulator is 32 bits, adds its active tuning word every clock and wraps modulo 2^32. The phase code p is accumulator bits [31:22]. Each output register holds the sample for the accumulator value of the previous cycle.
- R3: Shape code 0 (sine) outputs m for p in 0..511 and −m for p in 512..1023, where m = round(511·sin((i+0.5)·π/512)). Here i = p[7:0] when p[8] is 0 and 255 − p[7:0] when p[8] is 1.
- R4: Shape code 1 (square) gives +511 when p < t and −511 otherwise, where t = floor(d·1024/100) and d is the duty percentage.
- R5: Shape code 2 (triangle) gives 2p − 511 for p < 512 and 511 − 2(p − 512) otherwise.
- R6: Shape code 3 (sawtooth) rises for p < t as −511 + floor(p·U/65536), with U = floor(1022·65536/t). From p ≥ t it falls as 511 − floor((p − t)·D/65536), with D = floor(1022·65536/(1024 − t)). The break point t is the same as in R4.
- R7: A written duty below 1 is held as 1 and one above 99 is held as 99.
- R8: Output = 512 + floor(s·(g+1)/256), where s is the signed shape value and g the channel's 8-bit gain. Outputs therefore stay within 1..1023.
- R9: Writes go to pending registers. A channel's pending tuning word, shape, duty and gain become active in the clock after the accumulator step that carries out of bit 31. Channel B uses A's carry instead of its own while locked.
- R10: Address 8 bit 0 sets locked mode and address 9 sets the offset N. Writes above 119 are held as 119. Lock and offset become active on A's carry. While locked, B's phase is bits [31:22] of (A's accumulator + N·35791394) mod 2^32.
- R11: Addresses 0–3 write channel A's tuning word, shape, duty and gain. Addresses 4–7 write the same four settings for channel B. Writes to addresses 10–15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write value |
| dac_a | output | 10 | Channel A unsigned DAC code |
| dac_b | output | 10 | Channel B unsigned DAC code |

## Verification
The hardest behaviour to reach from the ports is the pending-to-active hand-over. It waits for an accumulator wrap, and the reset tuning word takes about 50,000 clocks to wrap once. The stimulus therefore writes fast tuning words during that first long period and checks that the slow sine keeps running until the wrap. After that, tuning words of 2^22 and near it step the phase code through every value in one period, so each shape is swept over all 1024 phase points. Locked mode is entered with B holding a different tuning word, which exercises B's hand-over being moved to channel A's carry.

// File: rtl/dds_pkg.sv
// Shared widths, shape codes and the per-channel active configuration.
// Assumes the phase code is as wide as the DAC word, so that the triangle's
// slope of two codes per phase step spans the full scale.
package dds_pkg;
    parameter int ACC_W      = 32;
    parameter int DAC_W      = 10;
    parameter int PH_W       = DAC_W;
    parameter int GAIN_W     = 8;
    parameter int DUTY_W     = 7;
    parameter int DUTY_MIN   = 1;
    parameter int DUTY_MAX   = 99;
    parameter int DUTY_DEN   = 100;
    parameter int SLOPE_FRAC = 16;
    parameter int SLOPE_W    = 27;

    typedef enum logic [1:0] {
        SHP_SINE   = 2'd0,
        SHP_SQUARE = 2'd1,
        SHP_TRI    = 2'd2,
        SHP_SAW    = 2'd3
    } shape_e;

    typedef struct packed {
        logic [ACC_W-1:0]   ftw;
        shape_e             shape;
        logic [PH_W-1:0]    thr;
        logic [SLOPE_W-1:0] up;
        logic [SLOPE_W-1:0] dn;
        logic [GAIN_W-1:0]  gain;
    } chan_cfg_t;

    // Turn raw settings into the form the shape logic consumes: break point and ramp slopes.
    function automatic chan_cfg_t make_cfg(input logic [ACC_W-1:0] ftw, input shape_e shp,
                                           input logic [DUTY_W-1:0] duty,
                                           input logic [GAIN_W-1:0] gain);
        chan_cfg_t   c;
        int unsigned t;
        int unsigned span;
        t       = (int'(duty) << PH_W) / DUTY_DEN;
        span    = 2 * ((1 << (DAC_W - 1)) - 1);
        c.ftw   = ftw;
        c.shape = shp;
        c.thr   = PH_W'(t);
        c.up    = SLOPE_W'((span << SLOPE_FRAC) / t);
        c.dn    = SLOPE_W'((span << SLOPE_FRAC) / ((1 << PH_W) - t));
        c.gain  = gain;
        return c;
    endfunction
endpackage

// File: rtl/dds_phase_acc.sv
// Phase accumulator: adds the tuning word every clock and flags the carry
// out of the top bit. Assumes the tuning word is the channel's active one.
module dds_phase_acc import dds_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] ftw,
    output logic [ACC_W-1:0] acc,
    output logic             wrap
);
    logic [ACC_W:0] sum;

    // Next accumulator value with its carry.
    assign sum  = {1'b0, acc} + {1'b0, ftw};
    assign wrap = sum[ACC_W];

    // Advance the phase, starting from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/dds_cfg_slot.sv
// One channel's settings: a pending copy written by the host and an active
// copy loaded from it on the load strobe. Assumes load is a wrap event.
module dds_cfg_slot import dds_pkg::*; #(
    parameter logic [ACC_W-1:0] RST_FTW = 85899
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_field,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             load,
    output chan_cfg_t        act
);
    localparam logic [DUTY_W-1:0] DUTY_RST = DUTY_W'(DUTY_DEN / 2);

    logic [ACC_W-1:0]  ftw_p;
    shape_e            shape_p;
    logic [DUTY_W-1:0] duty_p;
    logic [GAIN_W-1:0] gain_p;
    logic [DUTY_W-1:0] duty_in;

    // Hold the written duty inside the legal percentage range.
    always_comb begin
        if (wr_data < ACC_W'(DUTY_MIN))      duty_in = DUTY_W'(DUTY_MIN);
        else if (wr_data > ACC_W'(DUTY_MAX)) duty_in = DUTY_W'(DUTY_MAX);
        else                                 duty_in = wr_data[DUTY_W-1:0];
    end

    // Capture host writes into the pending copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_p   <= RST_FTW;
            shape_p <= SHP_SINE;
            duty_p  <= DUTY_RST;
            gain_p  <= '1;
        end else if (wr_en) begin
            case (wr_field)
                2'd0:    ftw_p   <= wr_data;
                2'd1:    shape_p <= shape_e'(wr_data[1:0]);
                2'd2:    duty_p  <= duty_in;
                default: gain_p  <= wr_data[GAIN_W-1:0];
            endcase
        end
    end

    // Move pending settings into use only at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    act <= make_cfg(RST_FTW, SHP_SINE, DUTY_RST, '1);
        else if (load) act <= make_cfg(ftw_p, shape_p, duty_p, gain_p);
    end
endmodule

// File: rtl/dds_shape.sv
// Maps a phase code to a signed full-scale sample of the selected shape.
// Assumes PH_W equals DAC_W and PH_W >= 3; the sine table is built at elaboration.
module dds_shape import dds_pkg::*; (
    input  logic [PH_W-1:0]         phase,
    input  chan_cfg_t               cfg,
    output logic signed [DAC_W:0]   smp
);
    localparam int QA_W  = PH_W - 2;
    localparam int Q_N   = 1 << QA_W;
    localparam int MAG_W = DAC_W - 1;
    localparam int FS    = (1 << MAG_W) - 1;
    localparam int HALF  = 1 << (PH_W - 1);

    // Quarter sine magnitudes from a series expansion, rounded to the nearest code.
    function automatic logic [Q_N*MAG_W-1:0] build_qtab();
        logic [Q_N*MAG_W-1:0] tab;
        real x, term, sum_r;
        tab = '0;
        for (int i = 0; i < Q_N; i++) begin
            x     = (real'(i) + 0.5) * 3.14159265358979323846 / (2.0 * real'(Q_N));
            term  = x;
            sum_r = x;
            for (int k = 1; k < 10; k++) begin
                term  = -term * x * x / (real'(2 * k) * real'(2 * k + 1));
                sum_r = sum_r + term;
            end
            tab[i*MAG_W +: MAG_W] = MAG_W'($rtoi(real'(FS) * sum_r + 0.5));
        end
        return tab;
    endfunction

    localparam logic [Q_N*MAG_W-1:0] QTAB = build_qtab();

    logic [QA_W-1:0]  qidx;
    logic [MAG_W-1:0] qmag;
    longint           p, t, v;

    // Mirror the quarter table address in the second and fourth quarters.
    assign qidx = phase[PH_W-2] ? ~phase[QA_W-1:0] : phase[QA_W-1:0];
    assign qmag = QTAB[int'(qidx)*MAG_W +: MAG_W];

    // Select and evaluate the active shape.
    always_comb begin
        p = longint'(phase);
        t = longint'(cfg.thr);
        case (cfg.shape)
            SHP_SINE:   v = phase[PH_W-1] ? -longint'(qmag) : longint'(qmag);
            SHP_SQUARE: v = (p < t) ? longint'(FS) : -longint'(FS);
            SHP_TRI:    v = phase[PH_W-1] ? longint'(FS) - 2 * (p - HALF) : 2 * p - FS;
            default:    v = (p < t) ? -longint'(FS) + ((p * longint'(cfg.up)) >>> SLOPE_FRAC)
                                    : longint'(FS) - (((p - t) * longint'(cfg.dn)) >>> SLOPE_FRAC);
        endcase
        smp = (DAC_W+1)'(v);
    end
endmodule

// File: rtl/dds_scale_out.sv
// Scales a signed sample by (gain+1)/2^GAIN_W, re-biases it to mid-code and
// registers it onto the DAC bus. Assumes the sample lies within +/- full scale.
module dds_scale_out import dds_pkg::*; (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [DAC_W:0]  smp,
    input  logic [GAIN_W-1:0]      gain,
    output logic [DAC_W-1:0]       dac
);
    localparam int MID = 1 << (DAC_W - 1);

    int prod;

    // Signed product with floor scaling.
    assign prod = int'(smp) * (int'(gain) + 1);

    // Register the biased code, mid-scale during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) dac <= DAC_W'(MID);
        else        dac <= DAC_W'(MID + (prod >>> GAIN_W));
    end
endmodule

// File: rtl/dds_dual_gen.sv
// Two-channel waveform synthesizer top. Decodes host writes, runs one
// accumulator per channel and lets channel B follow A's phase plus an offset.
// Assumes one write per cycle; addresses 10..15 are not decoded.
module dds_dual_gen import dds_pkg::*; #(
    parameter logic [ACC_W-1:0] RST_FTW   = 85899,
    parameter int               OFF_STEPS = 120,
    parameter int               ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    output logic [DAC_W-1:0]  dac_a,
    output logic [DAC_W-1:0]  dac_b
);
    localparam int               OFF_W    = $clog2(OFF_STEPS);
    localparam logic [ACC_W-1:0] OFF_UNIT = ACC_W'((64'd1 << ACC_W) / 64'(OFF_STEPS));
    localparam int               NCH      = 2;

    chan_cfg_t              act   [NCH];
    logic [ACC_W-1:0]       acc   [NCH];
    logic                   wrap  [NCH];
    logic                   load  [NCH];
    logic [ACC_W-1:0]       src   [NCH];
    logic signed [DAC_W:0]  smp   [NCH];
    logic [DAC_W-1:0]       dac   [NCH];
    logic                   lock_p, lock_q;
    logic [OFF_W-1:0]       off_p, off_q;
    logic [ACC_W-1:0]       shifted;

    // Host writes to the shared lock and offset settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_p <= 1'b0;
            off_p  <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(8)) begin
            lock_p <= wr_data[0];
        end else if (wr_en && wr_addr == ADDR_W'(9)) begin
            off_p  <= (wr_data > ACC_W'(OFF_STEPS - 1)) ? OFF_W'(OFF_STEPS - 1) : wr_data[OFF_W-1:0];
        end
    end

    // Shared settings take effect on channel A's wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            off_q  <= '0;
        end else if (wrap[0]) begin
            lock_q <= lock_p;
            off_q  <= off_p;
        end
    end

    // Channel A's phase moved by the active offset.
    assign shifted = acc[0] + ACC_W'(ACC_W'(off_q) * OFF_UNIT);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g == 0) begin : g_lead
            assign load[g] = wrap[0];
            assign src[g]  = acc[0];
        end else begin : g_follow
            assign load[g] = lock_q ? wrap[0] : wrap[g];
            assign src[g]  = lock_q ? shifted : acc[g];
        end

        dds_cfg_slot #(.RST_FTW(RST_FTW)) u_cfg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && !wr_addr[ADDR_W-1] && (wr_addr[2] == 1'(g))),
            .wr_field (wr_addr[1:0]),
            .wr_data  (wr_data),
            .load     (load[g]),
            .act      (act[g])
        );

        dds_phase_acc u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .ftw   (act[g].ftw),
            .acc   (acc[g]),
            .wrap  (wrap[g])
        );

        dds_shape u_shape (
            .phase (src[g][ACC_W-1 -: PH_W]),
            .cfg   (act[g]),
            .smp   (smp[g])
        );

        dds_scale_out u_out (
            .clk   (clk),
            .rst_n (rst_n),
            .smp   (smp[g]),
            .gain  (act[g].gain),
            .dac   (dac[g])
        );
    end

    assign dac_a = dac[0];
    assign dac_b = dac[1];
endmodule

// File: rtl/dds_dual_gen_chk.sv
// Property checker for the dual synthesizer, bound into every instance.
module dds_dual_gen_chk import dds_pkg::*; #(
    parameter int OFF_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DAC_W-1:0] dac_a,
    input logic [DAC_W-1:0] dac_b,
    input logic             wrap_a,
    input logic             load_b,
    input chan_cfg_t        act_a,
    input chan_cfg_t        act_b,
    input logic             lock_q,
    input logic [OFF_W-1:0] off_q
);
    localparam int THR_LO = (DUTY_MIN << PH_W) / DUTY_DEN;
    localparam int THR_HI = (DUTY_MAX << PH_W) / DUTY_DEN;

    // R8
    out_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_a != '0) && (dac_b != '0));

    // R9
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_a |=> $stable(act_a));

    // R9
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_b |=> $stable(act_b));

    // R4
    square_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a.shape == SHP_SQUARE && act_a.gain == '1) |=> (dac_a == 1 || dac_a == '1));

    // R7
    thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(act_a.thr) >= THR_LO) && (int'(act_a.thr) <= THR_HI) &&
        (int'(act_b.thr) >= THR_LO) && (int'(act_b.thr) <= THR_HI));

    // R10
    lock_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && off_q == '0 && act_a.shape == act_b.shape && act_a.thr == act_b.thr &&
         act_a.gain == act_b.gain) |=> (dac_a == dac_b));
endmodule

bind dds_dual_gen dds_dual_gen_chk #(.OFF_W(OFF_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .dac_a  (dac_a),
    .dac_b  (dac_b),
    .wrap_a (wrap[0]),
    .load_b (load[1]),
    .act_a  (act[0]),
    .act_b  (act[1]),
    .lock_q (lock_q),
    .off_q  (off_q)
);

// File: tb/sim_dds_dual_gen.sv
// Cycle-level bench: an arithmetic model of both channels predicts every
// output sample, compared at the falling edge.
module sim_dds_dual_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [9:0]  dac_a, dac_b;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";
    int    qtab [256];

    // model state
    bit [31:0] macc [2];
    bit [31:0] s_ftw [2], a_ftw [2];
    int        s_shp [2], a_shp [2], s_duty [2], a_duty [2], s_gain [2], a_gain [2];
    bit        s_lock, a_lock;
    int        s_off, a_off;
    int        exp_a = 512, exp_b = 512;

    dds_dual_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dac_a(dac_a), .dac_b(dac_b)
    );

    always #5 clk = ~clk;

    function automatic int samp(int shp, int duty, int gain, int p);
        longint s, t, up, dn;
        int idx;
        t = longint'(duty) * 1024 / 100;
        case (shp)
            0: begin
                idx = p % 256;
                if ((p / 256) % 2 == 1) idx = 255 - idx;
                s = qtab[idx];
                if (p >= 512) s = -s;
            end
            1: s = (p < t) ? 511 : -511;
            2: s = (p < 512) ? 2 * p - 511 : 511 - 2 * (p - 512);
            default: begin
                up = (1022 * 65536) / t;
                dn = (1022 * 65536) / (1024 - t);
                if (p < t) s = -511 + ((longint'(p) * up) >>> 16);
                else       s = 511 - (((longint'(p) - t) * dn) >>> 16);
            end
        endcase
        return int'(512 + ((s * (gain + 1)) >>> 8));
    endfunction

    // model step at each rising edge
    always @(posedge clk) begin
        bit [31:0] sh;
        bit [32:0] na, nb;
        bit        evb;
        int        d;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                macc[c] = 0; s_ftw[c] = 85899; a_ftw[c] = 85899;
                s_shp[c] = 0; a_shp[c] = 0; s_duty[c] = 50; a_duty[c] = 50;
                s_gain[c] = 255; a_gain[c] = 255;
            end
            s_lock = 0; a_lock = 0; s_off = 0; a_off = 0;
            exp_a = 512; exp_b = 512;
        end else begin
            sh    = macc[0] + 32'(a_off) * 32'd35791394;
            exp_a = samp(a_shp[0], a_duty[0], a_gain[0], int'(macc[0][31:22]));
            exp_b = samp(a_shp[1], a_duty[1], a_gain[1],
                         a_lock ? int'(sh[31:22]) : int'(macc[1][31:22]));
            na = {1'b0, macc[0]} + {1'b0, a_ftw[0]};
            nb = {1'b0, macc[1]} + {1'b0, a_ftw[1]};
            macc[0] = na[31:0];
            macc[1] = nb[31:0];
            evb = a_lock ? na[32] : nb[32];
            if (na[32]) begin
                a_ftw[0] = s_ftw[0]; a_shp[0] = s_shp[0]; a_duty[0] = s_duty[0]; a_gain[0] = s_gain[0];
                a_lock = s_lock; a_off = s_off;
            end
            if (evb) begin
                a_ftw[1] = s_ftw[1]; a_shp[1] = s_shp[1]; a_duty[1] = s_duty[1]; a_gain[1] = s_gain[1];
            end
            if (wr_en) begin
                d = (wr_data < 1) ? 1 : ((wr_data > 99) ? 99 : int'(wr_data));
                if (wr_addr < 8) begin
                    case (wr_addr[1:0])
                        2'd0: s_ftw[wr_addr[2]]  = wr_data;
                        2'd1: s_shp[wr_addr[2]]  = int'(wr_data[1:0]);
                        2'd2: s_duty[wr_addr[2]] = d;
                        default: s_gain[wr_addr[2]] = int'(wr_data[7:0]);
                    endcase
                end else if (wr_addr == 8) begin
                    s_lock = wr_data[0];
                end else if (wr_addr == 9) begin
                    s_off = (wr_data > 119) ? 119 : int'(wr_data);
                end
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            checks += 2;
            if (int'(dac_a) != exp_a) begin
                errors++;
                $display("FAIL %s dac_a actual %0d expected %0d at cycle %0d", tag, dac_a, exp_a, cyc);
            end
            if (int'(dac_b) != exp_b) begin
                errors++;
                $display("FAIL %s dac_b actual %0d expected %0d at cycle %0d", tag, dac_b, exp_b, cyc);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual %0d expected below 190000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input int addr, input int unsigned data);
        @(negedge clk);
        wr_en   <= 1'b1;
        wr_addr <= 4'(addr);
        wr_data <= data;
        @(negedge clk);
        wr_en   <= 1'b0;
    endtask

    task automatic run(input int n, input string t);
        tag = t;
        repeat (n) @(negedge clk);
    endtask

    task automatic both(input int field, input int unsigned va, input int unsigned vb);
        wr(field, va);
        wr(4 + field, vb);
    endtask

    initial begin
        for (int i = 0; i < 256; i++)
            qtab[i] = $rtoi(511.0 * $sin((real'(i) + 0.5) * 3.14159265358979323846 / 512.0) + 0.5);
        repeat (2) @(negedge clk);
        chk_on = 1'b1;
        run(3, "R1 reset mid-code");
        rst_n <= 1'b1;
        run(200, "R1 default sine");
        // R9: pending writes must wait for the slow first wrap
        both(0, 32'h0040_0000, 32'h0030_0000);
        wr(12, 32'h0000_0001);   // R11 unmapped
        wr(15, 32'hFFFF_FFFF);   // R11 unmapped
        wr(10, 32'h0000_0003);   // R11 unmapped
        run(50200, "R9 pending until wrap R11");
        run(2800, "R3 sine sweep");
        both(1, 1, 1);
        run(2800, "R4 square duty 50");
        both(2, 1, 99);
        run(2800, "R4 square duty 1 and 99");
        both(2, 0, 200);
        run(2800, "R7 duty clamp");
        both(1, 2, 2);
        run(2800, "R5 triangle");
        both(1, 3, 3);
        both(2, 50, 50);
        run(2800, "R6 sawtooth 50");
        both(2, 1, 99);
        run(2800, "R6 sawtooth 1 and 99");
        both(2, 25, 73);
        run(2800, "R6 sawtooth 25 and 73");
        both(1, 2, 2);
        both(3, 0, 127);
        run(2800, "R8 gain 0 and 127");
        both(1, 0, 1);
        both(3, 7, 200);
        run(2800, "R8 gain 7 and 200");
        both(3, 255, 255);
        both(0, 32'h0050_0003, 32'h0012_3457);
        run(8000, "R2 odd tuning words");
        both(0, 32'h0040_0000, 32'h0040_0000);
        both(1, 0, 0);
        run(8000, "R9 retune");
        wr(8, 1);
        wr(9, 0);
        run(2800, "R10 lock offset 0");
        wr(9, 30);
        run(2800, "R10 lock offset 30");
        wr(9, 119);
        run(2800, "R10 lock offset 119");
        wr(9, 200);
        run(2800, "R10 offset clamp");
        wr(5, 2);
        wr(9, 60);
        run(2800, "R10 lock triangle offset 60");
        wr(4, 32'h0011_0000);
        run(2800, "R10 lock ignores own tuning");
        wr(8, 0);
        run(6000, "R9 unlock");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule